// File: doc/BRIEF.md
# SPI Master with Two-Stage Clock Prescaler

This block is a serial peripheral interface master. Its serial clock comes from the system clock through two dividers in series. The first stage divides by a power of four: 1, 4, 16 or 64. The second stage divides by any whole number from 1 to 8. One serial clock half-period lasts as many system clock cycles as the product of the two ratios. The duty cycle is therefore always 50%.

A word is 8 or 16 bits long and moves most significant bit first. The following are all set from static configuration inputs:
- the level of the clock while idle;
- the edge on which outgoing data changes;
- whether incoming data is captured in the middle or at the end of each bit.

Software-side logic writes a word to start a transfer. It watches the busy flag and collects the received word from a read port. A receive-full flag marks that read port as holding a new word. Dropping the enable input aborts any transfer in progress.

Top module: `spi_master`

## Requirements
- R1: While a transfer runs, sck_o toggles every N clk_i cycles, where N = 4^pri_sel_i × (sec_sel_i + 1). The first toggle comes N cycles after the edge that accepts the write.
- R2: With wide_i = 1 a transfer moves 16 bits and uses all of tx_data_i. With wide_i = 0 it moves 8 bits and uses tx_data_i[7:0]. Bits go most significant first, and sck_o makes exactly two toggles per bit.
- R3: When no transfer is running, sck_o equals cpol_i. The first toggle of a transfer goes to the opposite, active level.
- R4: With launch_a2i_i = 1, mosi_o shows the first bit from the accepted write and changes only on active-to-idle toggles. With launch_a2i_i = 0, mosi_o changes only on idle-to-active toggles, and the first bit is present before the first toggle.
- R5: With smp_end_i = 0, miso_i is captured on the toggle in the middle of each bit. With smp_end_i = 1, it is captured one half-period later, at the end of the bit. rx_data_o returns the word zero-extended to 16 bits, first received bit most significant.
- R6: tx_busy_o rises in the cycle after an accepted write. It stays high for T × N cycles, where T = 2 × bits, plus 1 when launch_a2i_i = 0 and smp_end_i = 1.
- R7: A write while tx_busy_o is high, or while en_i is low, is ignored. The running transfer and its data are unchanged, or no transfer starts.
- R8: rx_full_o is set in the cycle where tx_busy_o falls at the end of a completed transfer. rx_rd_i clears it.
- R9: Driving en_i low clears tx_busy_o and returns sck_o to cpol_i at the next edge. The receive flag and the buffer keep their values.
- R10: After reset, tx_busy_o, rx_full_o, sck_o and rx_data_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low aborts and blocks transfers |
| pri_sel_i | input | 2 | First-stage ratio code: 4^code |
| sec_sel_i | input | 3 | Second-stage ratio code: code + 1 |
| wide_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit |
| cpol_i | input | 1 | Serial clock idle level |
| launch_a2i_i | input | 1 | 1: data changes on active-to-idle toggles |
| smp_end_i | input | 1 | 1: capture at end of bit, 0: at middle |
| tx_wr_i | input | 1 | Write strobe for the transmit word |
| tx_data_i | input | 16 | Transmit word |
| rx_rd_i | input | 1 | Read strobe, clears the receive-full flag |
| rx_data_o | output | 16 | Last received word |
| tx_busy_o | output | 1 | Transfer in progress |
| rx_full_o | output | 1 | Unread received word present |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest part to reach from the ports is the capture instant. With end-of-bit capture, the master samples on the same toggle where the peer launches its next bit. In the idle-to-active launch mode, it also samples the last bit in an extra half-period after the final toggle. A peer that holds its data for the whole bit cannot tell either case apart from middle capture. The bench therefore drives miso_i with the correct bit only in the single cycle before the capture edge that the requirements predict, and with random noise in every other cycle. A write is also injected a few cycles into a running transfer to show that it has no effect on the shifted data or the busy length.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  typedef struct packed {
    logic cpol;
    logic launch_a2i;
    logic smp_end;
    logic wide;
  } spi_cfg_t;
endpackage

// File: rtl/spi_mst_prescaler.sv
module spi_mst_prescaler #(
  parameter int PRI_SEL_W = 2,
  parameter int SEC_SEL_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [PRI_SEL_W-1:0] pri_sel_i,
  input  logic [SEC_SEL_W-1:0] sec_sel_i,
  output logic                 tick_o
);
  localparam int PRI_CODES = 1 << PRI_SEL_W;
  localparam int PRI_MAX   = 1 << (2 * (PRI_CODES - 1));
  localparam int PRI_CW    = $clog2(PRI_MAX);

  logic [PRI_CW-1:0]    pri_cnt_q, pri_lim;
  logic [SEC_SEL_W-1:0] sec_cnt_q;
  logic                 pri_tick;

  always_comb begin
    pri_lim  = PRI_CW'((32'd1 << (2 * pri_sel_i)) - 32'd1);
    pri_tick = run_i && (pri_cnt_q == pri_lim);
    tick_o   = pri_tick && (sec_cnt_q == sec_sel_i);
  end

  // stage one: power-of-four divider
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pri_cnt_q <= '0;
    else if (!run_i)    pri_cnt_q <= '0;
    else if (pri_tick)  pri_cnt_q <= '0;
    else                pri_cnt_q <= pri_cnt_q + 1'b1;
  end

  // stage two: counts stage-one ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sec_cnt_q <= '0;
    else if (!run_i)    sec_cnt_q <= '0;
    else if (tick_o)    sec_cnt_q <= '0;
    else if (pri_tick)  sec_cnt_q <= sec_cnt_q + 1'b1;
  end

  a_r1_pri_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $stable(pri_sel_i) |-> pri_cnt_q <= pri_lim);
  a_r1_sec_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $stable(sec_sel_i) |-> sec_cnt_q <= sec_sel_i);
  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pri_cnt_q == '0 && sec_cnt_q == '0);
endmodule

// File: rtl/spi_mst_phase.sv
module spi_mst_phase
  import spi_mst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     tick_i,
  input  spi_cfg_t cfg_i,
  output logic     toggle_o,
  output logic     launch_o,
  output logic     sample_o,
  output logic     last_o
);
  localparam int MAX_T = 2 * DATA_W + 1;
  localparam int TW    = $clog2(MAX_T + 1);

  logic [TW-1:0] t_q;
  int w, total, tn, ln, k, s, e;

  always_comb begin
    w     = cfg_i.wide ? DATA_W : DATA_W / 2;
    s     = cfg_i.launch_a2i ? 0 : 1;
    e     = cfg_i.smp_end ? 1 : 0;
    total = 2 * w + s * e;
    tn    = int'(t_q) + 1;
    ln    = tn - s;
    k     = int'(t_q) - s - e;
    toggle_o = tick_i && (tn <= 2 * w);
    // launch of bit i>0 lands on half-period 2i+s
    launch_o = tick_i && (ln >= 2) && ((ln % 2) == 0) && ((ln / 2) < w);
    // capture of bit i lands on half-period 2i+1+s+e
    sample_o = tick_i && (k >= 0) && ((k % 2) == 0) && ((k / 2) < w);
    last_o   = tick_i && (tn == total);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      t_q <= '0;
    else if (!run_i)  t_q <= '0;
    else if (tick_i)  t_q <= t_q + 1'b1;
  end

  a_r6_tick_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $stable(cfg_i) |-> int'(t_q) < total);
  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !(toggle_o || launch_o || sample_o || last_o));
  a_r6_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> t_q == '0);
endmodule

// File: rtl/spi_mst_rxbuf.sv
module spi_mst_rxbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (load_i) begin
      data_o <= word_i;
      full_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end

  a_r8_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !load_i |=> !full_o);
  a_r8_load_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_o && data_o == $past(word_i));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_o));
endmodule

// File: rtl/spi_master.sv
module spi_master
  import spi_mst_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PRI_SEL_W = 2,
  parameter int SEC_SEL_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [PRI_SEL_W-1:0] pri_sel_i,
  input  logic [SEC_SEL_W-1:0] sec_sel_i,
  input  logic                 wide_i,
  input  logic                 cpol_i,
  input  logic                 launch_a2i_i,
  input  logic                 smp_end_i,
  input  logic                 tx_wr_i,
  input  logic [DATA_W-1:0]    tx_data_i,
  input  logic                 rx_rd_i,
  output logic [DATA_W-1:0]    rx_data_o,
  output logic                 tx_busy_o,
  output logic                 rx_full_o,
  output logic                 sck_o,
  output logic                 mosi_o,
  input  logic                 miso_i
);
  localparam int HALF_W = DATA_W / 2;

  spi_cfg_t          cfg;
  logic              busy_q, sck_q, accept;
  logic              tick, toggle, launch, sample, last;
  logic [DATA_W-1:0] tx_sr_q, rx_sr_q, rx_sr_nx, rx_word;
  logic              rx_load;

  always_comb begin
    cfg.cpol       = cpol_i;
    cfg.launch_a2i = launch_a2i_i;
    cfg.smp_end    = smp_end_i;
    cfg.wide       = wide_i;
    accept   = en_i && tx_wr_i && !busy_q;
    rx_sr_nx = {rx_sr_q[DATA_W-2:0], miso_i};
    rx_word  = sample ? rx_sr_nx : rx_sr_q;
    rx_load  = en_i && busy_q && last;
  end

  spi_mst_prescaler #(
    .PRI_SEL_W (PRI_SEL_W),
    .SEC_SEL_W (SEC_SEL_W)
  ) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_q),
    .pri_sel_i (pri_sel_i),
    .sec_sel_i (sec_sel_i),
    .tick_o    (tick)
  );

  spi_mst_phase #(
    .DATA_W (DATA_W)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy_q),
    .tick_i   (tick),
    .cfg_i    (cfg),
    .toggle_o (toggle),
    .launch_o (launch),
    .sample_o (sample),
    .last_o   (last)
  );

  spi_mst_rxbuf #(
    .DATA_W (DATA_W)
  ) u_rxbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rx_load),
    .word_i (rx_word),
    .rd_i   (rx_rd_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      sck_q  <= cpol_i;
    end else if (accept) begin
      busy_q  <= 1'b1;
      sck_q   <= cpol_i;
      tx_sr_q <= wide_i ? tx_data_i : {tx_data_i[HALF_W-1:0], {HALF_W{1'b0}}};
      rx_sr_q <= '0;
    end else if (busy_q) begin
      if (toggle) sck_q   <= ~sck_q;
      if (launch) tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
      if (sample) rx_sr_q <= rx_sr_nx;
      if (last)   busy_q  <= 1'b0;
    end else begin
      sck_q <= cpol_i;
    end
  end

  assign tx_busy_o = busy_q;
  assign sck_o     = sck_q;
  assign mosi_o    = tx_sr_q[DATA_W-1];

  a_r6_busy_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> tx_busy_o);
  a_r7_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_o && en_i && tx_wr_i && !launch |=> $stable(tx_sr_q));
  a_r7_disabled_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tx_busy_o);
  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sck_o == $past(cpol_i));
  a_r3_end_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_busy_o) && $stable(cpol_i) |-> sck_o == cpol_i);
  a_r8_full_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_busy_o) && $past(en_i) |-> rx_full_o);
  a_r4_mosi_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_o && en_i && !launch |=> $stable(mosi_o));
endmodule

// File: tb/spi_master_tb.sv
module spi_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  pri = '0;
  logic [2:0]  sec = '0;
  logic        wide = 1'b0, cpol = 1'b0, a2i = 1'b1, smpe = 1'b0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, miso = 1'b0;
  logic [15:0] tx_data = '0;
  logic [15:0] rx_data;
  logic        busy, rx_full, sck, mosi;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spi_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pri_sel_i(pri), .sec_sel_i(sec),
    .wide_i(wide), .cpol_i(cpol), .launch_a2i_i(a2i), .smp_end_i(smpe),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .tx_busy_o(busy), .rx_full_o(rx_full), .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int ratio(input int p, input int sc);
    return (1 << (2 * p)) * (sc + 1);
  endfunction

  // per-transfer state
  int c, n, w, s, e, t_tot, edges, bc, bad_t;
  logic [15:0] mo, sw;
  logic prev_sck;
  bit inject;

  task automatic step();
    if (c % n == 0) begin
      int k;
      k = c / n - 1 - s - e;
      if (k >= 0 && (k % 2) == 0 && (k / 2) < w) miso = sw[w - 1 - k / 2];
      else miso = 1'($urandom);
    end else miso = 1'($urandom);
    if (sck != prev_sck) begin
      edges++;
      if (c - 1 != edges * n) bad_t++;
      if ((a2i && (edges % 2) == 1) || (!a2i && (edges % 2) == 0)) mo = {mo[14:0], mosi};
      prev_sck = sck;
    end
    if (busy) bc++;
    if (inject && c == 3) begin tx_wr = 1'b1; tx_data = ~tx_data; end
    if (inject && c == 4) tx_wr = 1'b0;
  endtask

  task automatic xfer(input int p, input int sc, input bit wd, input bit cp, input bit la,
                      input bit se, input logic [15:0] txw, input logic [15:0] slv, input bit inj);
    logic [15:0] exp_mo, exp_rx;
    @(negedge clk);
    pri = 2'(p); sec = 3'(sc); wide = wd; cpol = cp; a2i = la; smpe = se;
    repeat (2) @(negedge clk);
    chk(sck == cp, "R3 idle level", int'(sck), int'(cp));
    n = ratio(p, sc); w = wd ? 16 : 8; s = la ? 0 : 1; e = se ? 1 : 0;
    t_tot = 2 * w + s * e;
    edges = 0; bc = 0; bad_t = 0; mo = '0; sw = slv; prev_sck = sck; inject = inj;
    tx_wr = 1'b1; tx_data = txw;
    @(negedge clk);
    tx_wr = 1'b0; c = 1;
    chk(busy == 1'b1, "R6 busy rises", int'(busy), 1);
    forever begin
      step();
      if (!busy || c >= 40000) break;
      @(negedge clk);
      c++;
    end
    exp_mo = wd ? txw : {8'h00, txw[7:0]};
    exp_rx = wd ? slv : {8'h00, slv[7:0]};
    chk(bad_t == 0, "R1 half-period spacing", bad_t, 0);
    chk(edges == 2 * w, "R2 toggle count", edges, 2 * w);
    chk(mo == exp_mo, "R4 shifted-out word", int'(mo), int'(exp_mo));
    chk(rx_data == exp_rx, "R5 received word", int'(rx_data), int'(exp_rx));
    chk(bc == t_tot * n, "R6 busy length", bc, t_tot * n);
    chk(rx_full == 1'b1, "R8 full set", int'(rx_full), 1);
    chk(sck == cp, "R3 idle after", int'(sck), int'(cp));
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    chk(rx_full == 1'b0, "R8 read clears", int'(rx_full), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy == 0, "R10 busy", int'(busy), 0);
    chk(rx_full == 0, "R10 full", int'(rx_full), 0);
    chk(sck == 0, "R10 sck", int'(sck), 0);
    chk(rx_data == 0, "R10 data", int'(rx_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: write while disabled
    tx_wr = 1'b1; tx_data = 16'hA5A5;
    @(negedge clk);
    tx_wr = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R7 disabled write", int'(busy), 0);
    en = 1'b1;

    // directed corners: fastest clock in all four timing modes
    xfer(0, 0, 1, 0, 1, 0, 16'hC35A, 16'h96E1, 0);
    xfer(0, 0, 1, 1, 1, 1, 16'h1234, 16'hFEDC, 0);
    xfer(0, 0, 1, 0, 0, 0, 16'h8001, 16'h7FFE, 0);
    xfer(0, 0, 1, 1, 0, 1, 16'h5AA5, 16'hA55A, 0);
    xfer(0, 1, 0, 0, 0, 1, 16'hFF3C, 16'h00C3, 0);
    // R7: write injected mid-transfer
    xfer(1, 1, 1, 0, 1, 0, 16'hBEEF, 16'h1357, 1);
    // slowest ratio, both word lengths
    xfer(3, 7, 0, 1, 1, 0, 16'h00B6, 16'h0049, 0);
    xfer(3, 7, 1, 0, 0, 1, 16'h2C71, 16'hD38E, 0);

    for (int i = 0; i < 16; i++)
      xfer(int'($urandom % 3), int'($urandom % 8), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 0);

    // R9: abort mid-transfer
    @(negedge clk);
    pri = 2'd1; sec = 3'd1; wide = 1'b1; cpol = 1'b1; a2i = 1'b1; smpe = 1'b0;
    @(negedge clk);
    tx_wr = 1'b1; tx_data = 16'h0F0F;
    @(negedge clk);
    tx_wr = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1, "R9 running before abort", int'(busy), 1);
    en = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R9 abort clears busy", int'(busy), 0);
    chk(sck == 1, "R9 abort idles sck", int'(sck), 1);
    chk(rx_full == 0, "R9 flag kept", int'(rx_full), 0);
    en = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0, "R9 stays idle", int'(busy), 0);

    summary();
    $finish;
  end
endmodule